// File: doc/BRIEF.md
# Line BER Defect Monitor

This block sits behind a SONET/SDH line overhead processor and turns the per-frame count of line parity (B2) errors into Signal Degrade (SD) and Signal Fail (SF) defect decisions. All time windows are counted in ticks of a 1 ms strobe. SD is declared when a programmable window holds more errors than a programmable threshold. Once declared, SD is cleared by a fixed rule: a 256-tick window that holds fewer than 8 errors.

SF is judged by two detectors that run side by side. One is a long interval detector and the other a short burst detector, and each has its own window length and threshold. Either detector can declare SF. SF clears only after each detector has closed a whole window at or below its threshold since the declaration. Every change of SD or SF sets a sticky interrupt flag that clears when read. The flags drive an active-low interrupt through per-flag enables. A small read port returns either the defect status byte, which also carries six defect inputs from elsewhere in the overhead processor, or the interrupt flag byte.

Top module: `lber_mon`

## Requirements
- R1: After reset the SD and SF states, all interrupt flags and `rd_data` are 0, and `irq_n` is 1.
- R2: A window of length L closes on every L-th `ms_tick` counted from reset. Its count includes errors presented in the closing tick's cycle. The count restarts from zero in the next cycle.
- R3: Error accumulators saturate at all-ones and do not wrap. A saturated count still exceeds a threshold of all-ones minus one.
- R4: While SD is clear, SD is declared when an SD window of `sd_win` ticks closes with a count greater than `sd_thr`.
- R5: While SD is declared, SD clears when a fixed 256-tick window closes with fewer than 8 errors. A count of exactly 8 keeps SD declared.
- R6: While SF is clear, SF is declared when the interval window (`sfi_win`, `sfi_thr`) or the burst window (`sfb_win`, `sfb_thr`) closes with a count greater than its threshold.
- R7: A declared SF clears only when, since the declaration, each detector's most recent closed window is at or below its threshold.
- R8: The status byte (`rd_sel`=0) holds, from bit 0 to bit 7: `aux_def[0]`, `aux_def[1]`, `aux_def[2]`, SD, SF, `aux_def[3]`, `aux_def[4]`, `aux_def[5]`.
- R9: The interrupt byte (`rd_sel`=1) has bit 7 for a change of SF, bit 6 for a change of SD, and bits 5:0 at 0. Each change in either direction sets its bit. A read returns the byte and clears the bits it returned. A bit set in the same cycle as a read is kept.
- R10: `irq_n` is low while any flag whose enable is set is 1. `irq_en[1]` enables bit 7 and `irq_en[0]` enables bit 6. A masked flag leaves `irq_n` high.
- R11: Read data appears on `rd_data` in the cycle after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | 1 ms timing strobe, one cycle wide |
| err_vld | input | 1 | Frame error count valid |
| err_cnt | input | EW | B2 errors found in one frame |
| sd_win | input | TW | SD declare window length in ticks |
| sd_thr | input | CW | SD declare threshold |
| sfi_win | input | TW | SF interval window length in ticks |
| sfi_thr | input | CW | SF interval threshold |
| sfb_win | input | TW | SF burst window length in ticks |
| sfb_thr | input | CW | SF burst threshold |
| aux_def | input | 6 | Other defect states shown in the status byte |
| irq_en | input | 2 | Interrupt enables: [1] SF change, [0] SD change |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 selects status, 1 selects interrupt flags |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench checks the SD clearance boundary by putting exactly 8 errors into one 256-tick window and then 7 into the next. A design that used at-or-below instead of strictly below would release SD one window early. Errors that arrive in the same cycle as a closing tick must count toward the closing window, and a design that dropped them or pushed them into the next window would miss a burst declaration. A late read lands in the very cycle a flag sets, where a clear-wins design loses the SD change. A 300-frame overload shows whether the accumulator wraps below threshold. The bench also holds SF past a clean burst window until the slower interval window closes clean, which catches a design that clears on either detector alone.

// File: rtl/lber_pkg.sv
package lber_pkg;
  // status byte bit positions
  localparam int STS_LOS = 0;
  localparam int STS_SEF = 1;
  localparam int STS_LOF = 2;
  localparam int STS_SD  = 3;
  localparam int STS_SF  = 4;
  localparam int STS_KK  = 5;
  localparam int STS_S1  = 6;
  localparam int STS_RDI = 7;
  // interrupt flag bit positions
  localparam int FLG_SD  = 6;
  localparam int FLG_SF  = 7;
  // read selector values
  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_FLAGS  = 1'b1;
  // fixed SD clearance rule
  localparam int SD_CLR_TICKS = 256;
  localparam int SD_CLR_LIMIT = 8;

  typedef struct packed {
    logic done;
    logic over;
  } win_res_t;
endpackage

// File: rtl/lber_window.sv
module lber_window
  import lber_pkg::*;
#(
  parameter int EW = 8,
  parameter int CW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ms_tick,
  input  logic          err_vld,
  input  logic [EW-1:0] err_cnt,
  input  logic [TW-1:0] win_len,
  input  logic [CW-1:0] thresh,
  output win_res_t      res
);
  localparam logic [CW-1:0] ACC_MAX = '1;

  logic [TW-1:0] tcnt;
  logic [CW-1:0] acc;
  logic [CW:0]   wide;
  logic [CW-1:0] sum;
  logic          close;

  always_comb begin
    wide  = {1'b0, acc} + (err_vld ? (CW+1)'(err_cnt) : '0);
    sum   = wide[CW] ? ACC_MAX : wide[CW-1:0];
    close = ms_tick && (({1'b0, tcnt} + 1'b1) >= {1'b0, win_len});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt     <= '0;
      acc      <= '0;
      res.done <= 1'b0;
      res.over <= 1'b0;
    end else begin
      res.done <= close;
      res.over <= close && (sum > thresh);
      acc      <= close ? '0 : sum;
      if (ms_tick) tcnt <= close ? '0 : tcnt + 1'b1;
    end
  end

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_MAX && !close) |=> acc == ACC_MAX);
  p_done_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    res.done |-> $past(ms_tick));
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    res.done |-> acc == '0);
endmodule

// File: rtl/lber_defect.sv
module lber_defect
  import lber_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  win_res_t sd_dec,
  input  win_res_t sd_clr,
  input  win_res_t sf_int,
  input  win_res_t sf_bur,
  output logic     sd,
  output logic     sf,
  output logic     sd_chg,
  output logic     sf_chg
);
  logic cln_i, cln_b;
  logic fire, ci_n, cb_n, sd_n;

  always_comb begin
    fire = (sf_int.done && sf_int.over) || (sf_bur.done && sf_bur.over);
    ci_n = sf_int.done ? !sf_int.over : cln_i;
    cb_n = sf_bur.done ? !sf_bur.over : cln_b;
    sd_n = sd ? !(sd_clr.done && !sd_clr.over) : (sd_dec.done && sd_dec.over);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd <= 1'b0; sf <= 1'b0; sd_chg <= 1'b0; sf_chg <= 1'b0;
      cln_i <= 1'b0; cln_b <= 1'b0;
    end else begin
      sd     <= sd_n;
      sd_chg <= (sd_n != sd);
      if (!sf) begin
        sf     <= fire;
        sf_chg <= fire;
        cln_i  <= 1'b0;
        cln_b  <= 1'b0;
      end else if (ci_n && cb_n) begin
        sf     <= 1'b0;
        sf_chg <= 1'b1;
        cln_i  <= 1'b0;
        cln_b  <= 1'b0;
      end else begin
        sf_chg <= 1'b0;
        cln_i  <= ci_n;
        cln_b  <= cb_n;
      end
    end
  end

  p_sd_decl_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sd) |-> $past(sd_dec.done && sd_dec.over));
  p_sd_clr_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(sd) |-> $past(sd_clr.done && !sd_clr.over));
  p_sf_decl_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sf) |-> $past(fire));
  p_sf_clr_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sf) |-> $past((cln_i || (sf_int.done && !sf_int.over)) &&
                        (cln_b || (sf_bur.done && !sf_bur.over))));
endmodule

// File: rtl/lber_regs.sv
module lber_regs
  import lber_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sd,
  input  logic       sf,
  input  logic       sd_chg,
  input  logic       sf_chg,
  input  logic [5:0] aux_def,
  input  logic [1:0] irq_en,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       irq_n
);
  logic [7:0] flags, status, set_v, clr_v, en_v;

  always_comb begin
    status          = '0;
    status[STS_LOS] = aux_def[0];
    status[STS_SEF] = aux_def[1];
    status[STS_LOF] = aux_def[2];
    status[STS_SD]  = sd;
    status[STS_SF]  = sf;
    status[STS_KK]  = aux_def[3];
    status[STS_S1]  = aux_def[4];
    status[STS_RDI] = aux_def[5];
    set_v           = '0;
    set_v[FLG_SF]   = sf_chg;
    set_v[FLG_SD]   = sd_chg;
    en_v            = '0;
    en_v[FLG_SF]    = irq_en[1];
    en_v[FLG_SD]    = irq_en[0];
    clr_v           = (rd_en && rd_sel == SEL_FLAGS) ? flags : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      rd_data <= '0;
      irq_n   <= 1'b1;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      if (rd_en) rd_data <= (rd_sel == SEL_FLAGS) ? flags : status;
      irq_n <= !(|(flags & en_v));
    end
  end

  p_sf_flag_r9: assert property (@(posedge clk) disable iff (rst)
    sf_chg |=> flags[FLG_SF]);
  p_sd_flag_r9: assert property (@(posedge clk) disable iff (rst)
    sd_chg |=> flags[FLG_SD]);
  p_irq_src_r10: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(|(flags & en_v)));
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_data));
endmodule

// File: rtl/lber_mon.sv
module lber_mon
  import lber_pkg::*;
#(
  parameter int EW = 8,
  parameter int CW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ms_tick,
  input  logic          err_vld,
  input  logic [EW-1:0] err_cnt,
  input  logic [TW-1:0] sd_win,
  input  logic [CW-1:0] sd_thr,
  input  logic [TW-1:0] sfi_win,
  input  logic [CW-1:0] sfi_thr,
  input  logic [TW-1:0] sfb_win,
  input  logic [CW-1:0] sfb_thr,
  input  logic [5:0]    aux_def,
  input  logic [1:0]    irq_en,
  input  logic          rd_en,
  input  logic          rd_sel,
  output logic [7:0]    rd_data,
  output logic          irq_n
);
  localparam int NWIN = 4;
  localparam logic [TW-1:0] CLR_LEN = TW'(SD_CLR_TICKS);
  localparam logic [CW-1:0] CLR_THR = CW'(SD_CLR_LIMIT - 1);

  logic [NWIN-1:0][TW-1:0] lens;
  logic [NWIN-1:0][CW-1:0] thrs;
  win_res_t [NWIN-1:0]     res;
  logic sd, sf, sd_chg, sf_chg;

  assign lens = {sfb_win, sfi_win, CLR_LEN, sd_win};
  assign thrs = {sfb_thr, sfi_thr, CLR_THR, sd_thr};

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    lber_window #(.EW(EW), .CW(CW), .TW(TW)) u_win (
      .clk(clk), .rst(rst), .ms_tick(ms_tick), .err_vld(err_vld),
      .err_cnt(err_cnt), .win_len(lens[g]), .thresh(thrs[g]), .res(res[g]));
  end

  lber_defect u_def (
    .clk(clk), .rst(rst), .sd_dec(res[0]), .sd_clr(res[1]),
    .sf_int(res[2]), .sf_bur(res[3]), .sd(sd), .sf(sf),
    .sd_chg(sd_chg), .sf_chg(sf_chg));

  lber_regs u_regs (
    .clk(clk), .rst(rst), .sd(sd), .sf(sf), .sd_chg(sd_chg),
    .sf_chg(sf_chg), .aux_def(aux_def), .irq_en(irq_en), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_n(irq_n));
endmodule

// File: tb/tb_lber_mon.sv
module tb_lber_mon;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ms_tick = 1'b0, err_vld = 1'b0;
  logic [7:0]  err_cnt = '0;
  logic [15:0] sd_win = 16'd4, sd_thr = 16'd20;
  logic [15:0] sfi_win = 16'd16, sfi_thr = 16'd100;
  logic [15:0] sfb_win = 16'd2, sfb_thr = 16'd30;
  logic [5:0]  aux_def = '0;
  logic [1:0]  irq_en = 2'b11;
  logic        rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0]  rd_data;
  logic        irq_n;

  lber_mon dut (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit reported = 0;
  int k = 0, a_sdd = 0, a_sdc = 0, a_sfi = 0, a_sfb = 0;
  bit m_sd = 0, m_sf = 0, m_ci = 0, m_cb = 0, fl_sd = 0, fl_sf = 0, ch_sd = 0, ch_sf = 0;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !reported) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(int a, int b);
    return (a + b > 65535) ? 65535 : a + b;
  endfunction

  task automatic add_err(int e);
    a_sdd = sat(a_sdd, e); a_sdc = sat(a_sdc, e);
    a_sfi = sat(a_sfi, e); a_sfb = sat(a_sfb, e);
  endtask

  // transaction-level model of one tick: decisions per requirements
  task automatic model_tick();
    bit d_sdd, d_sdc, d_sfi, d_sfb, o_sdd, o_sdc, o_sfi, o_sfb, sd_n, fire, ci_n, cb_n;
    k++;
    d_sdd = (k % int'(sd_win)) == 0;  o_sdd = a_sdd > int'(sd_thr);
    d_sdc = (k % 256) == 0;           o_sdc = a_sdc >= 8;
    d_sfi = (k % int'(sfi_win)) == 0; o_sfi = a_sfi > int'(sfi_thr);
    d_sfb = (k % int'(sfb_win)) == 0; o_sfb = a_sfb > int'(sfb_thr);
    sd_n = m_sd ? !(d_sdc && !o_sdc) : (d_sdd && o_sdd);
    ch_sd = (sd_n != m_sd); m_sd = sd_n;
    if (ch_sd) fl_sd = 1;
    ch_sf = 0;
    fire = (d_sfi && o_sfi) || (d_sfb && o_sfb);
    if (!m_sf) begin
      if (fire) begin m_sf = 1; ch_sf = 1; end
      m_ci = 0; m_cb = 0;
    end else begin
      ci_n = d_sfi ? !o_sfi : m_ci;
      cb_n = d_sfb ? !o_sfb : m_cb;
      if (ci_n && cb_n) begin m_sf = 0; ch_sf = 1; m_ci = 0; m_cb = 0; end
      else begin m_ci = ci_n; m_cb = cb_n; end
    end
    if (ch_sf) fl_sf = 1;
    if (d_sdd) a_sdd = 0;
    if (d_sdc) a_sdc = 0;
    if (d_sfi) a_sfi = 0;
    if (d_sfb) a_sfb = 0;
  endtask

  task automatic rd(bit sel, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; rd_sel = sel;
    @(negedge clk); rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_flags(string tag);
    logic [7:0] d;
    rd(1'b1, d);
    chk(tag, d, {fl_sf, fl_sd, 6'b0});
    fl_sd = 0; fl_sf = 0;
  endtask

  // nfr frames with errors in [lo,hi], then a tick (optionally carrying errors)
  task automatic tick(int nfr, int lo, int hi, bit te_en, int te, bit rd_slot);
    logic [7:0] d, slot;
    bit p_sd, p_sf;
    int e;
    for (int i = 0; i < nfr; i++) begin
      @(negedge clk); e = $urandom_range(hi, lo);
      err_vld = 1'b1; err_cnt = 8'(e); add_err(e);
    end
    @(negedge clk);
    aux_def = 6'($urandom);
    ms_tick = 1'b1; err_vld = te_en; err_cnt = 8'(te);
    if (te_en) add_err(te);
    @(negedge clk); ms_tick = 1'b0; err_vld = 1'b0;
    slot = '0;
    if (rd_slot) begin
      @(negedge clk); rd_en = 1'b1; rd_sel = 1'b1;
      @(negedge clk); rd_en = 1'b0; slot = rd_data;
    end
    p_sd = fl_sd; p_sf = fl_sf;
    model_tick();
    if (rd_slot) begin
      chk("R9 read in flag-set cycle returns prior flags", slot, {p_sf, p_sd, 6'b0});
      fl_sd = ch_sd; fl_sf = ch_sf;
    end
    repeat (4) @(negedge clk);
    rd(1'b0, d);
    chk("R4 SD status bit", d[3], m_sd);
    chk("R6 SF status bit", d[4], m_sf);
    chk("R8 status layout", d, {aux_def[5:3], m_sf, m_sd, aux_def[2:0]});
    chk("R10 irq_n", irq_n, !((fl_sf && irq_en[1]) || (fl_sd && irq_en[0])));
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0);
  endtask

  task automatic align(int m);
    while ((k % m) != 0) tick(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq_n after reset", irq_n, 1);
    chk("R1 rd_data after reset", rd_data, 0);
    rd(1'b0, d); chk("R1 status after reset", d, 0);
    rd(1'b1, d); chk("R1 flags after reset", d, 0);
    repeat (3) @(negedge clk);
    chk("R11 rd_data holds without read", rd_data, 0);

    // random phase
    for (int i = 0; i < 150; i++) tick($urandom_range(3, 0), 0, $urandom_range(12, 0), 0, 0, 0);
    quiet(600);
    chk("R5 SD cleared after quiet", m_sd, 0);
    rd_flags("R9 flags after random phase");

    // R2: errors carried by the closing tick count in that burst window
    align(16);
    tick(0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 1, 31, 0);
    rd(1'b0, d); chk("R2 closing-cycle errors declare SF", d[4], 1);
    quiet(4);
    rd(1'b0, d); chk("R7 SF held until interval window clean", d[4], 1);
    quiet(10);
    rd(1'b0, d); chk("R7 SF cleared when both windows clean", d[4], 0);
    quiet(600);
    rd_flags("R9 flags after burst case");

    // R5: exactly 8 errors keep SD, 7 clear it
    align(256);
    tick(1, 25, 25, 0, 0, 0);
    quiet(255);
    rd(1'b0, d); chk("R4 SD declared by 25 errors", d[3], 1);
    for (int i = 0; i < 256; i++) tick((i < 8) ? 1 : 0, 1, 1, 0, 0, 0);
    rd(1'b0, d); chk("R5 eight errors keep SD", d[3], 1);
    for (int i = 0; i < 256; i++) tick((i < 7) ? 1 : 0, 1, 1, 0, 0, 0);
    rd(1'b0, d); chk("R5 seven errors clear SD", d[3], 0);
    rd_flags("R9 SD change flag both ways");

    // R9: read lands in the same cycle the SD flag sets
    align(4);
    tick(1, 25, 25, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 1);
    // R10: masking
    irq_en = 2'b10;
    repeat (3) @(negedge clk);
    chk("R10 masked SD flag keeps irq_n high", irq_n, 1);
    irq_en = 2'b11;
    repeat (3) @(negedge clk);
    chk("R10 enabled SD flag drives irq_n low", irq_n, 0);
    rd_flags("R9 flag kept over same-cycle read");
    repeat (3) @(negedge clk);
    chk("R10 irq_n released after read", irq_n, 1);

    // R3: saturation
    quiet(600);
    rd_flags("R9 flags before saturation case");
    align(16);
    sfi_thr = 16'hFFFE; sfb_thr = 16'hFFFE;
    tick(300, 255, 255, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0);
    rd(1'b0, d); chk("R3 saturated count exceeds max-1", d[4], 1);
    sfi_thr = 16'd100; sfb_thr = 16'd30;
    quiet(40);
    rd(1'b0, d); chk("R7 SF cleared after saturation", d[4], 0);
    rd_flags("R9 flags after saturation case");

    report();
    $finish;
  end
endmodule